// File: doc/BRIEF.md
# Scanning ADC Register Interface

This block sits between a byte-wide host bus and a multichannel successive-approximation converter. The host programs a scan window as a pair of channel numbers packed into one byte, picks how conversions are paced, and starts conversions. The block hands the converter a start pulse together with the channel to sample. It waits for the converter's done strobe and captures the raw result left-justified into a 16-bit word, which the host then reads as two bytes. After each conversion the channel pointer moves one step up through the window and wraps.

Conversions are started in three ways. A software write to the data address always starts one. A free-running internal divider can start them when the pacing field selects it. An external pace pin, passed through a synchronizer, can start one on each rising edge. A start that arrives while a conversion is in flight is dropped. A completed conversion can raise a pending flag, which is cleared by any write to the status address.

Top module: `adc_scan_regs`

## Requirements
- R1: After reset the result bytes, the scan register, the control register, the busy flag, the pending flag and the channel pointer are all zero.
- R2: A write of any value to offset 0x00 while idle sets busy on the next clock edge and gives a one-cycle `adc_start` pulse in that same cycle, with `adc_chan` equal to the current pointer.
- R3: The edge that samples `adc_done` high while busy clears busy and captures the result. Offset 0x01 then reads bits 15:8 of the result and offset 0x00 reads bits 7:0. The 12 valid raw bits 11:0 land in result bits 15:4, result bits 3:0 are zero, and raw bits 15:12 are discarded.
- R4: Offset 0x02 is the scan register: bits 3:0 hold the first channel and bits 7:4 the last channel. It reads back as written, and every write loads the pointer with the first channel.
- R5: After each conversion the pointer goes back to the first channel if it equals the last channel. Otherwise it becomes pointer+1 modulo 16 when `strap_single_ended` is 1, or modulo 8 when it is 0. In the modulo-8 case only bits 2:0 of the channel nibbles are used.
- R6: A read of offset 0x08 returns busy in bit 7, `strap_unipolar` in bit 6, `strap_single_ended` in bit 5, the pending flag in bit 4 and the channel pointer in bits 3:0.
- R7: Offset 0x09 is the control register and reads back as written. Bit 7 is the interrupt enable, bits 6:4 the interrupt level, bit 2 the transfer enable and bits 1:0 the pacing source (0 software only, 2 external pin, 3 internal divider).
- R8: A conversion that completes while bit 7 of the control register is set raises the pending flag. Any write to offset 0x08 clears it. When both fall on the same edge the flag ends up set.
- R9: A start request that arrives while busy, including one on the same edge as `adc_done`, is ignored: it gives no `adc_start` and leaves the pointer unchanged.
- R10: With pacing 3, idle starts occur every `PACE_DIV` cycles. With pacing 2, each rising edge of `ext_pace` gives one start and a held level gives no further starts. With pacing 0, neither source starts anything.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe; `bus_rdata` is valid the following cycle |
| bus_rdata | output | 8 | Registered read data |
| strap_unipolar | input | 1 | Unipolar input range strap |
| strap_single_ended | input | 1 | 1: 16 single-ended channels, 0: 8 differential |
| ext_pace | input | 1 | Asynchronous external pace pin |
| adc_start | output | 1 | One-cycle conversion start to converter |
| adc_chan | output | CHAN_W | Channel for the conversion being started |
| adc_done | input | 1 | Converter done strobe |
| adc_raw | input | 16 | Raw converter result, right-aligned |

## Verification
Two pairs of events can meet on one clock edge. A converter done can land with a host write that clears the pending flag, and a done can land with a software trigger write. The bench provokes both by holding back the converter stub and driving `adc_done` and the bus write in the same cycle. In the first case it checks that the status byte still shows the flag set and busy clear. In the second it checks that no start pulse follows and that the pointer has advanced only once.

// File: rtl/adc_scan_pkg.sv
`timescale 1ns/1ps
package adc_scan_pkg;

  localparam int DATA_W = 16;

  localparam logic [7:0] OFS_DATA_LO = 8'h00;
  localparam logic [7:0] OFS_DATA_HI = 8'h01;
  localparam logic [7:0] OFS_SCAN    = 8'h02;
  localparam logic [7:0] OFS_STAT    = 8'h08;
  localparam logic [7:0] OFS_CTRL    = 8'h09;

  typedef enum logic [1:0] {
    PACE_SOFT = 2'd0,
    PACE_RSVD = 2'd1,
    PACE_EXT  = 2'd2,
    PACE_INT  = 2'd3
  } pace_e;

  typedef struct packed {
    logic       irq_en;
    logic [2:0] irq_lvl;
    logic       spare;
    logic       xfer_en;
    pace_e      pace;
  } ctrl_t;

  typedef struct packed {
    logic       busy;
    logic       unipolar;
    logic       single_ended;
    logic       pend;
    logic [3:0] ptr;
  } stat_t;

endpackage

// File: rtl/adc_scan_ptr.sv
`timescale 1ns/1ps
module adc_scan_ptr #(
  parameter int CHAN_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [CHAN_W-1:0] load_val,
  input  logic [CHAN_W-1:0] first,
  input  logic [CHAN_W-1:0] last,
  input  logic              advance,
  input  logic              single_ended,
  output logic [CHAN_W-1:0] ptr
);

  localparam logic [CHAN_W-1:0] FULL_MASK = '1;
  localparam logic [CHAN_W-1:0] HALF_MASK = FULL_MASK >> 1;

  logic [CHAN_W-1:0] mask;
  logic [CHAN_W-1:0] first_m;
  logic [CHAN_W-1:0] last_m;
  logic [CHAN_W-1:0] step;

  always_comb begin
    mask    = single_ended ? FULL_MASK : HALF_MASK;
    first_m = first & mask;
    last_m  = last & mask;
    step    = (ptr == last_m) ? first_m : ((ptr + CHAN_W'(1)) & mask);
  end

  // a scan-register write wins over an advance on the same edge
  always_ff @(posedge clk) begin
    if (rst)          ptr <= '0;
    else if (load)    ptr <= load_val & mask;
    else if (advance) ptr <= step;
  end

endmodule

// File: rtl/adc_pace_gen.sv
`timescale 1ns/1ps
module adc_pace_gen
  import adc_scan_pkg::*;
#(
  parameter int PACE_DIV    = 20,
  parameter int SYNC_STAGES = 2
) (
  input  logic  clk,
  input  logic  rst,
  input  pace_e mode,
  input  logic  ext_in,
  output logic  tick
);

  localparam int CNT_W = (PACE_DIV > 1) ? $clog2(PACE_DIV) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PACE_DIV - 1);

  logic [CNT_W-1:0]       cnt;
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   ext_prev;
  logic                   int_hit;
  logic                   ext_rise;

  always_ff @(posedge clk) begin
    if (rst)                   cnt <= '0;
    else if (mode != PACE_INT) cnt <= '0;
    else if (cnt == CNT_LAST)  cnt <= '0;
    else                       cnt <= cnt + CNT_W'(1);
  end

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) sync_q[0] <= 1'b0;
          else     sync_q[0] <= ext_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) sync_q[g] <= 1'b0;
          else     sync_q[g] <= sync_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) ext_prev <= 1'b0;
    else     ext_prev <= sync_q[SYNC_STAGES-1];
  end

  always_comb begin
    int_hit  = (mode == PACE_INT) && (cnt == CNT_LAST);
    ext_rise = (mode == PACE_EXT) && sync_q[SYNC_STAGES-1] && !ext_prev;
    tick     = int_hit || ext_rise;
  end

endmodule

// File: rtl/adc_conv_ctrl.sv
`timescale 1ns/1ps
module adc_conv_ctrl
  import adc_scan_pkg::*;
#(
  parameter int RES_BITS = 12,
  parameter int CHAN_W   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              trig_sw,
  input  logic              trig_pace,
  input  logic [CHAN_W-1:0] chan_in,
  input  logic              adc_done,
  input  logic [DATA_W-1:0] adc_raw,
  output logic              busy,
  output logic              adc_start,
  output logic [CHAN_W-1:0] adc_chan,
  output logic [DATA_W-1:0] result,
  output logic              conv_done
);

  localparam int PAD = DATA_W - RES_BITS;

  logic [DATA_W-1:0] justified;

  generate
    if (PAD == 0) begin : g_full
      assign justified = adc_raw;
    end else begin : g_left
      logic unused_raw_hi;
      assign unused_raw_hi = ^adc_raw[DATA_W-1:RES_BITS];
      assign justified = {adc_raw[RES_BITS-1:0], {PAD{1'b0}}};
    end
  endgenerate

  assign conv_done = busy && adc_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      adc_start <= 1'b0;
      adc_chan  <= '0;
      result    <= '0;
    end else begin
      adc_start <= 1'b0;
      if (conv_done) begin
        busy   <= 1'b0;
        result <= justified;
      end else if (!busy && (trig_sw || trig_pace)) begin
        busy      <= 1'b1;
        adc_start <= 1'b1;
        adc_chan  <= chan_in;
      end
    end
  end

endmodule

// File: rtl/adc_reg_bank.sv
`timescale 1ns/1ps
module adc_reg_bank
  import adc_scan_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int CHAN_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [7:0]        bus_rdata,
  input  logic              busy,
  input  logic              conv_done,
  input  logic [DATA_W-1:0] result,
  input  logic [CHAN_W-1:0] ptr,
  input  logic              unipolar,
  input  logic              single_ended,
  output logic              trig_sw,
  output logic              scan_wr,
  output logic [7:0]        scan_q,
  output ctrl_t             ctrl_q,
  output logic              pend
);

  function automatic logic hit(input logic [7:0] ofs);
    return bus_addr == ofs[ADDR_W-1:0];
  endfunction

  stat_t      stat;
  logic [7:0] rd_next;
  logic       stat_wr;

  always_comb begin
    trig_sw = bus_wr && hit(OFS_DATA_LO);
    scan_wr = bus_wr && hit(OFS_SCAN);
    stat_wr = bus_wr && hit(OFS_STAT);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      scan_q <= '0;
      ctrl_q <= '0;
    end else if (bus_wr) begin
      if (hit(OFS_SCAN)) scan_q <= bus_wdata;
      if (hit(OFS_CTRL)) ctrl_q <= ctrl_t'(bus_wdata);
    end
  end

  // a new completion outranks a clear landing on the same edge
  always_ff @(posedge clk) begin
    if (rst)                           pend <= 1'b0;
    else if (conv_done && ctrl_q.irq_en) pend <= 1'b1;
    else if (stat_wr)                  pend <= 1'b0;
  end

  always_comb begin
    stat = '{busy: busy, unipolar: unipolar, single_ended: single_ended,
             pend: pend, ptr: 4'(ptr)};
    rd_next = '0;
    if (hit(OFS_DATA_LO))      rd_next = result[7:0];
    else if (hit(OFS_DATA_HI)) rd_next = result[15:8];
    else if (hit(OFS_SCAN))    rd_next = scan_q;
    else if (hit(OFS_STAT))    rd_next = stat;
    else if (hit(OFS_CTRL))    rd_next = ctrl_q;
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_next;
  end

endmodule

// File: rtl/adc_scan_regs.sv
`timescale 1ns/1ps
module adc_scan_regs
  import adc_scan_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int CHAN_W      = 4,
  parameter int RES_BITS    = 12,
  parameter int PACE_DIV    = 20,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [7:0]        bus_rdata,
  input  logic              strap_unipolar,
  input  logic              strap_single_ended,
  input  logic              ext_pace,
  output logic              adc_start,
  output logic [CHAN_W-1:0] adc_chan,
  input  logic              adc_done,
  input  logic [15:0]       adc_raw
);

  logic              busy_w;
  logic              conv_done_w;
  logic              trig_sw_w;
  logic              pace_tick_w;
  logic              scan_wr_w;
  logic              pend_w;
  logic [7:0]        scan_w;
  ctrl_t             ctrl_w;
  logic [CHAN_W-1:0] ptr_w;
  logic [DATA_W-1:0] result_w;

  adc_reg_bank #(.ADDR_W(ADDR_W), .CHAN_W(CHAN_W)) u_regs (
    .clk(clk), .rst(rst),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .busy(busy_w), .conv_done(conv_done_w), .result(result_w),
    .ptr(ptr_w), .unipolar(strap_unipolar),
    .single_ended(strap_single_ended),
    .trig_sw(trig_sw_w), .scan_wr(scan_wr_w), .scan_q(scan_w),
    .ctrl_q(ctrl_w), .pend(pend_w)
  );

  adc_scan_ptr #(.CHAN_W(CHAN_W)) u_ptr (
    .clk(clk), .rst(rst),
    .load(scan_wr_w), .load_val(bus_wdata[CHAN_W-1:0]),
    .first(scan_w[CHAN_W-1:0]), .last(scan_w[4 +: CHAN_W]),
    .advance(conv_done_w), .single_ended(strap_single_ended),
    .ptr(ptr_w)
  );

  adc_pace_gen #(.PACE_DIV(PACE_DIV), .SYNC_STAGES(SYNC_STAGES)) u_pace (
    .clk(clk), .rst(rst), .mode(ctrl_w.pace), .ext_in(ext_pace),
    .tick(pace_tick_w)
  );

  adc_conv_ctrl #(.RES_BITS(RES_BITS), .CHAN_W(CHAN_W)) u_conv (
    .clk(clk), .rst(rst),
    .trig_sw(trig_sw_w), .trig_pace(pace_tick_w), .chan_in(ptr_w),
    .adc_done(adc_done), .adc_raw(adc_raw),
    .busy(busy_w), .adc_start(adc_start), .adc_chan(adc_chan),
    .result(result_w), .conv_done(conv_done_w)
  );

endmodule

// File: rtl/adc_scan_regs_chk.sv
`timescale 1ns/1ps
module adc_scan_regs_chk
  import adc_scan_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int CHAN_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [7:0]        bus_wdata,
  input logic              bus_wr,
  input logic              adc_start,
  input logic              adc_done,
  input logic              busy,
  input logic              pend,
  input ctrl_t             ctrl,
  input logic [CHAN_W-1:0] ptr,
  input logic              se
);

  localparam logic [CHAN_W-1:0] HALF = {1'b0, {(CHAN_W-1){1'b1}}};

  logic trig_wr, stat_wr, scan_wr;
  assign trig_wr = bus_wr && (bus_addr == OFS_DATA_LO[ADDR_W-1:0]);
  assign stat_wr = bus_wr && (bus_addr == OFS_STAT[ADDR_W-1:0]);
  assign scan_wr = bus_wr && (bus_addr == OFS_SCAN[ADDR_W-1:0]);

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (!busy && !pend && ptr == '0));

  assert_trig_starts_R2: assert property (@(posedge clk) disable iff (rst)
    (trig_wr && !busy) |=> (busy && adc_start));

  assert_start_single_R2: assert property (@(posedge clk) disable iff (rst)
    adc_start |=> !adc_start);

  assert_done_idles_R3: assert property (@(posedge clk) disable iff (rst)
    (busy && adc_done) |=> !busy);

  assert_scan_load_R4: assert property (@(posedge clk) disable iff (rst)
    scan_wr |=> (ptr == (se ? $past(bus_wdata[CHAN_W-1:0])
                            : ($past(bus_wdata[CHAN_W-1:0]) & HALF))));

  assert_pend_set_R8: assert property (@(posedge clk) disable iff (rst)
    (busy && adc_done && ctrl.irq_en) |=> pend);

  assert_pend_clear_R8: assert property (@(posedge clk) disable iff (rst)
    (stat_wr && !(busy && adc_done && ctrl.irq_en)) |=> !pend);

  assert_busy_trig_drop_R9: assert property (@(posedge clk) disable iff (rst)
    (trig_wr && busy) |=> !adc_start);

  assert_soft_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    (ctrl.pace == PACE_SOFT && !trig_wr) |=> !adc_start);

endmodule

bind adc_scan_regs adc_scan_regs_chk #(.ADDR_W(ADDR_W), .CHAN_W(CHAN_W)) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_wr(bus_wr), .adc_start(adc_start), .adc_done(adc_done),
  .busy(busy_w), .pend(pend_w), .ctrl(ctrl_w), .ptr(ptr_w),
  .se(strap_single_ended)
);

// File: tb/adc_scan_regs_tb.sv
`timescale 1ns/1ps
module adc_scan_regs_tb;

  localparam int PACE_DIV = 20;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_rdata;
  logic       strap_unipolar = 1'b1;
  logic       strap_single_ended = 1'b1;
  logic       ext_pace = 1'b0;
  logic       adc_start;
  logic [3:0] adc_chan;
  logic       adc_done = 1'b0;
  logic [15:0] adc_raw = '0;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  int conv_no  = 0;

  // {single_ended, scan byte, conversion count}
  localparam logic [16:0] SCAN_VEC [5] = '{
    {1'b1, 8'h30, 8'd6},
    {1'b1, 8'h55, 8'd3},
    {1'b1, 8'h1E, 8'd5},
    {1'b0, 8'h16, 8'd5},
    {1'b0, 8'hF9, 8'd8}
  };

  adc_scan_regs #(.PACE_DIV(PACE_DIV)) u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .strap_unipolar(strap_unipolar), .strap_single_ended(strap_single_ended),
    .ext_pace(ext_pace), .adc_start(adc_start), .adc_chan(adc_chan),
    .adc_done(adc_done), .adc_raw(adc_raw)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [7:0] d);
    bus_addr = a; bus_rd = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  function automatic logic [11:0] stub_val(input logic [3:0] ch, input int k);
    return 12'((int'(ch) * 12'h111 + k * 12'h05B) & 12'hFFF);
  endfunction

  task automatic finish_conv(input int lat, input logic [11:0] v);
    repeat (lat) @(negedge clk);
    adc_done = 1'b1; adc_raw = {4'hA, v};
    @(negedge clk);
    adc_done = 1'b0; adc_raw = '0;
  endtask

  task automatic serve(input int lat, output logic [3:0] ch,
                       output logic [11:0] v, output bit seen, output int t);
    seen = adc_start;
    for (int i = 0; i < 400 && !seen; i++) begin
      @(negedge clk);
      seen = adc_start;
    end
    ch = adc_chan; t = cyc; v = '0;
    if (seen) begin
      v = stub_val(ch, conv_no);
      conv_no++;
      finish_conv(lat, v);
    end
  endtask

  task automatic count_starts(input int cycles, output int n);
    n = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (adc_start) n++;
    end
  endtask

  initial begin
    logic [7:0]  d;
    logic [3:0]  ch;
    logic [11:0] v;
    bit          seen;
    int          t1, t2, t3, n;
    int          p, f, l, m;

    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // reset state
    bus_read(4'h0, d); check("R1 result low after reset", d, 0);
    bus_read(4'h1, d); check("R1 result high after reset", d, 0);
    bus_read(4'h2, d); check("R1 scan register after reset", d, 0);
    bus_read(4'h9, d); check("R1 control after reset", d, 0);
    bus_read(4'h8, d); check("R6 status after reset", d, 8'h60);
    check("R1 no start after reset", adc_start, 0);

    // table of scan windows
    for (int e = 0; e < 5; e++) begin
      strap_single_ended = SCAN_VEC[e][16];
      bus_write(4'h2, SCAN_VEC[e][15:8]);
      bus_read(4'h2, d); check("R4 scan readback", d, SCAN_VEC[e][15:8]);
      m = SCAN_VEC[e][16] ? 15 : 7;
      f = SCAN_VEC[e][11:8] & m;
      l = SCAN_VEC[e][15:12] & m;
      p = f;
      for (int k = 0; k < int'(SCAN_VEC[e][7:0]); k++) begin
        bus_write(4'h0, 8'h5A);
        serve(1 + k % 3, ch, v, seen, t1);
        check("R2 software start seen", seen, 1);
        check("R5 channel sequence", ch, p);
        bus_read(4'h1, d); check("R3 result high byte", d, (int'(v) << 4) >> 8);
        bus_read(4'h0, d); check("R3 result low byte", d, (int'(v) << 4) & 8'hF0);
        p = (p == l) ? f : ((p + 1) & m);
      end
      bus_read(4'h8, d);
      check("R6 status pointer nibble", d & 8'h0F, p);
      check("R6 status strap bit", (d >> 5) & 1, SCAN_VEC[e][16]);
    end

    strap_single_ended = 1'b1;
    bus_write(4'h2, 8'h00);

    // start timing and a trigger while busy
    bus_write(4'h0, 8'h00);
    check("R2 start pulse after trigger write", adc_start, 1);
    check("R2 channel at start", adc_chan, 0);
    bus_write(4'h0, 8'hFF);
    check("R9 no start from trigger while busy", adc_start, 0);
    bus_read(4'h8, d); check("R6 busy bit while converting", (d >> 7) & 1, 1);
    finish_conv(1, 12'h123);
    bus_read(4'h8, d); check("R3 busy clear after done", (d >> 7) & 1, 0);
    count_starts(5, n); check("R9 dropped trigger not replayed", n, 0);

    // control register readback
    bus_write(4'h9, 8'hB4);
    bus_read(4'h9, d); check("R7 control readback", d, 8'hB4);

    // done and pending clear on the same edge
    bus_write(4'h9, 8'h80);
    bus_write(4'h0, 8'h00);
    @(negedge clk);
    adc_done = 1'b1; adc_raw = 16'h0ABC;
    bus_addr = 4'h8; bus_wdata = 8'h00; bus_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    adc_done = 1'b0; adc_raw = '0; bus_wr = 1'b0;
    bus_read(4'h8, d);
    check("R8 set wins over same-edge clear", (d >> 4) & 1, 1);
    check("R3 busy clear after coincident done", (d >> 7) & 1, 0);
    bus_read(4'h1, d); check("R3 coincident result high", d, 8'hAB);
    bus_write(4'h8, 8'h37);
    bus_read(4'h8, d); check("R8 status write clears pending", (d >> 4) & 1, 0);

    // completion with interrupt enable off
    bus_write(4'h9, 8'h00);
    bus_write(4'h0, 8'h00);
    finish_conv(2, 12'h001);
    bus_read(4'h8, d); check("R8 no pending when disabled", (d >> 4) & 1, 0);

    // trigger and done on the same edge, window 3..4
    bus_write(4'h2, 8'h43);
    bus_write(4'h0, 8'h00);
    @(negedge clk);
    adc_done = 1'b1; adc_raw = 16'h0555;
    bus_addr = 4'h0; bus_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    adc_done = 1'b0; adc_raw = '0; bus_wr = 1'b0;
    check("R9 trigger on done edge ignored", adc_start, 0);
    count_starts(4, n); check("R9 no late start", n, 0);
    bus_read(4'h8, d); check("R9 pointer advanced once", d & 8'h8F, 8'h04);

    // internal pacer
    bus_write(4'h2, 8'h20);
    bus_write(4'h9, 8'h03);
    serve(3, ch, v, seen, t1); check("R10 internal pacer start", seen, 1);
    check("R10 pacer channel 0", ch, 0);
    serve(3, ch, v, seen, t2); check("R10 pacer channel 1", ch, 1);
    serve(3, ch, v, seen, t3); check("R10 pacer channel 2", ch, 2);
    check("R10 pacer interval", t2 - t1, PACE_DIV);
    check("R10 pacer interval repeat", t3 - t2, PACE_DIV);
    bus_write(4'h9, 8'h00);
    count_starts(3 * PACE_DIV, n); check("R10 software mode quiet", n, 0);

    // external pacer
    bus_write(4'h9, 8'h02);
    ext_pace = 1'b1;
    serve(2, ch, v, seen, t1); check("R10 external edge start", seen, 1);
    count_starts(10, n); check("R10 held level no restart", n, 0);
    ext_pace = 1'b0;
    repeat (4) @(negedge clk);
    ext_pace = 1'b1;
    serve(2, ch, v, seen, t1); check("R10 second external edge", seen, 1);
    ext_pace = 1'b0;
    bus_write(4'h9, 8'h00);
    repeat (4) @(negedge clk);
    ext_pace = 1'b1;
    count_starts(10, n); check("R10 external edge ignored in software mode", n, 0);
    ext_pace = 1'b0;

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule